// File: doc/BRIEF.md
# AND-Rotate and Masked-Subtract Unit

This unit performs two combined byte operations for an 8-bit processor datapath. The first operation ANDs the accumulator with an operand and rotates the result right through carry. It then derives the flags from that rotated value and can apply a packed-BCD adjustment. The second operation ANDs the index register with the accumulator, subtracts an operand and reports the borrow through carry.

The surrounding core supplies the current accumulator, index register, carry and decimal flags, an operand byte and an operation select. It pulses a one-cycle enable when the result should be committed. The new accumulator, index register and the N, Z, C and V flags are held in registers on the output side.

A build parameter states whether the host core has decimal arithmetic. When that parameter is off, the decimal flag has no effect.

Top module: `arsx_unit`

## Requirements
- R1: A synchronous reset drives every output (a_out, x_out, n_out, z_out, c_out, v_out) to zero on the next clock edge.
- R2: While en is low and reset is inactive, all outputs keep their values across clock edges.
- R3: With op_sel=0 (rotate operation) in binary mode, the edge that samples en high loads a_out with {c_in, m[7:1]}, where m = a_in & operand. On that edge n_out becomes a_out bit 7 and z_out becomes 1 exactly when a_out is zero.
- R4: In binary rotate, c_out becomes bit 6 of the rotated value and v_out becomes bit 6 XOR bit 5 of the rotated value.
- R5: In decimal rotate (DEC_EN=1 and d_in=1), if m[3:0] + m[0] is greater than 5, the low nibble of the rotated value is replaced by its value plus 6, modulo 16. The high nibble is not changed by this step.
- R6: In decimal rotate, c_out is 1 exactly when m[7:4] + m[4] is greater than 5. When c_out is 1, 0x60 is added modulo 256 to the value left by R5.
- R7: In decimal rotate, n_out, z_out and v_out are taken from the rotated value before the R5 and R6 corrections.
- R8: With DEC_EN=0, d_in has no effect and the rotate operation always follows R3 and R4.
- R9: With op_sel=1 (subtract operation), x_out becomes ((x_in & a_in) - operand) mod 256. c_out is 1 when no borrow occurs, i.e. when (x_in & a_in) >= operand. n_out and z_out are taken from the new x_out.
- R10: The subtract operation loads a_out with a_in and keeps v_out at its previous value.
- R11: The rotate operation loads x_out with x_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | One-cycle commit strobe |
| op_sel | input | 1 | 0 = AND-rotate, 1 = masked subtract |
| operand | input | 8 | Operand byte |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| c_in | input | 1 | Current carry flag |
| d_in | input | 1 | Current decimal flag |
| a_out | output | 8 | Registered new accumulator |
| x_out | output | 8 | Registered new index register |
| n_out | output | 1 | Registered negative flag |
| z_out | output | 1 | Registered zero flag |
| c_out | output | 1 | Registered carry flag |
| v_out | output | 1 | Registered overflow flag |

## Verification
Every result and flag is due exactly one clock edge after the edge that samples en high. On cycles without en, the same edge must leave the outputs unchanged. The bench drives its inputs on the falling edge and updates its reference model for the one rising edge that follows. It then compares all outputs on the next falling edge, so each comparison covers exactly one register stage. A decimal-capable instance and a binary-only instance receive the same stimulus and are each compared against their own model.

// File: rtl/arsx_pkg.sv
package arsx_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = BYTE_W / 2;

   typedef enum logic {
      OP_ARR = 1'b0,
      OP_SBX = 1'b1
   } arsx_op_e;

   typedef struct packed {
      logic [BYTE_W-1:0] acc;
      logic [BYTE_W-1:0] idx;
      logic              n;
      logic              z;
      logic              c;
      logic              v;
   } arsx_res_t;
endpackage

// File: rtl/arsx_arr_core.sv
module arsx_arr_core
   import arsx_pkg::*;
#(
   parameter bit DEC_EN = 1'b1,
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] x_in,
   input  logic              c_in,
   input  logic              d_in,
   output arsx_res_t         res
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] rot;

   assign masked = a_in & operand;
   assign rot    = {c_in, masked[DATA_W-1:1]};

   generate
      if (DEC_EN) begin : g_dec
         logic [HALF:0]     lo_sum;
         logic [HALF:0]     hi_sum;
         logic              lo_fix;
         logic              hi_fix;
         logic [HALF-1:0]   lo_adj;
         logic [DATA_W-1:0] stage1;
         logic [DATA_W-1:0] stage2;

         always_comb begin
            lo_sum = {1'b0, masked[HALF-1:0]} + {{HALF{1'b0}}, masked[0]};
            hi_sum = {1'b0, masked[DATA_W-1:HALF]} + {{HALF{1'b0}}, masked[HALF]};
            lo_fix = d_in && (lo_sum > (HALF+1)'(5));
            hi_fix = d_in && (hi_sum > (HALF+1)'(5));
            lo_adj = rot[HALF-1:0] + HALF'(6);
            stage1 = lo_fix ? {rot[DATA_W-1:HALF], lo_adj} : rot;
            stage2 = hi_fix ? stage1 + DATA_W'(8'h60) : stage1;
         end

         always_comb begin
            res.acc = stage2;
            res.idx = x_in;
            res.n   = rot[DATA_W-1];
            res.z   = (rot == '0);
            res.v   = rot[DATA_W-2] ^ rot[DATA_W-3];
            res.c   = d_in ? hi_fix : rot[DATA_W-2];
         end
      end else begin : g_bin
         logic unused_d;
         assign unused_d = d_in;

         always_comb begin
            res.acc = rot;
            res.idx = x_in;
            res.n   = rot[DATA_W-1];
            res.z   = (rot == '0);
            res.v   = rot[DATA_W-2] ^ rot[DATA_W-3];
            res.c   = rot[DATA_W-2];
         end
      end
   endgenerate
endmodule

// File: rtl/arsx_sbx_core.sv
module arsx_sbx_core
   import arsx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] operand,
   input  logic              v_hold,
   output arsx_res_t         res
);
   logic [DATA_W-1:0] masked;
   logic [DATA_W:0]   diff;

   assign masked = x_in & a_in;
   assign diff   = {1'b0, masked} - {1'b0, operand};

   always_comb begin
      res.acc = a_in;
      res.idx = diff[DATA_W-1:0];
      res.n   = diff[DATA_W-1];
      res.z   = (diff[DATA_W-1:0] == '0);
      res.c   = ~diff[DATA_W];
      res.v   = v_hold;
   end
endmodule

// File: rtl/arsx_unit.sv
module arsx_unit
   import arsx_pkg::*;
#(
   parameter bit DEC_EN = 1'b1,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              op_sel,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic              c_in,
   input  logic              d_in,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] x_out,
   output logic              n_out,
   output logic              z_out,
   output logic              c_out,
   output logic              v_out
);
   if (DATA_W != BYTE_W) begin : g_width_chk
      $error("arsx_unit: DATA_W must equal 8");
   end

   arsx_res_t arr_res;
   arsx_res_t sbx_res;
   arsx_res_t nxt;
   arsx_res_t cur;

   arsx_arr_core #(.DEC_EN(DEC_EN), .DATA_W(DATA_W)) u_arr (
      .a_in    (a_in),
      .operand (operand),
      .x_in    (x_in),
      .c_in    (c_in),
      .d_in    (d_in),
      .res     (arr_res)
   );

   arsx_sbx_core #(.DATA_W(DATA_W)) u_sbx (
      .a_in    (a_in),
      .x_in    (x_in),
      .operand (operand),
      .v_hold  (cur.v),
      .res     (sbx_res)
   );

   assign nxt = (arsx_op_e'(op_sel) == OP_SBX) ? sbx_res : arr_res;

   always_ff @(posedge clk) begin
      if (rst)     cur <= '0;
      else if (en) cur <= nxt;
   end

   assign a_out = cur.acc;
   assign x_out = cur.idx;
   assign n_out = cur.n;
   assign z_out = cur.z;
   assign c_out = cur.c;
   assign v_out = cur.v;

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (a_out == '0 && x_out == '0 && !n_out && !z_out && !c_out && !v_out));

   // R2
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(a_out) && $stable(x_out) && $stable({n_out, z_out, c_out, v_out})));

   // R4
   a_r4_bin_flags: assert property (@(posedge clk) disable iff (rst)
      (en && !op_sel && (!DEC_EN || !d_in)) |=>
         (c_out == a_out[DATA_W-2] && v_out == (a_out[DATA_W-2] ^ a_out[DATA_W-3])));

   // R10
   a_r10_sbx_keeps: assert property (@(posedge clk) disable iff (rst)
      (en && op_sel) |=> (a_out == $past(a_in) && v_out == $past(v_out)));

   // R11
   a_r11_arr_keeps_x: assert property (@(posedge clk) disable iff (rst)
      (en && !op_sel) |=> (x_out == $past(x_in)));

   // R9
   a_r9_sbx_nz: assert property (@(posedge clk) disable iff (rst)
      (en && op_sel) |=> (n_out == x_out[DATA_W-1] && z_out == (x_out == '0)));
endmodule

// File: tb/arsx_unit_bench.sv
module arsx_unit_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       op_sel = 1'b0;
   logic [7:0] operand = '0;
   logic [7:0] a_in = '0;
   logic [7:0] x_in = '0;
   logic       c_in = 1'b0;
   logic       d_in = 1'b0;

   logic [7:0] a_d, x_d, a_b, x_b;
   logic       n_d, z_d, c_d, v_d, n_b, z_b, c_b, v_b;

   int total = 0;
   int bad   = 0;

   int ea [2];
   int ex [2];
   int en_f [2];
   int ez [2];
   int ec [2];
   int ev [2];

   always #10 clk = ~clk;

   arsx_unit #(.DEC_EN(1'b1)) u_arsx_unit (
      .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .operand(operand),
      .a_in(a_in), .x_in(x_in), .c_in(c_in), .d_in(d_in),
      .a_out(a_d), .x_out(x_d), .n_out(n_d), .z_out(z_d), .c_out(c_d), .v_out(v_d));

   arsx_unit #(.DEC_EN(1'b0)) u_arsx_unit_bin (
      .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .operand(operand),
      .a_in(a_in), .x_in(x_in), .c_in(c_in), .d_in(d_in),
      .a_out(a_b), .x_out(x_b), .n_out(n_b), .z_out(z_b), .c_out(c_b), .v_out(v_b));

   task automatic model(input int k, input bit dec_ok);
      int m, r, cc;
      if (rst) begin
         ea[k] = 0; ex[k] = 0; en_f[k] = 0; ez[k] = 0; ec[k] = 0; ev[k] = 0;
      end else if (en) begin
         if (op_sel) begin
            m = int'(x_in) & int'(a_in);
            r = m - int'(operand);
            ex[k] = r & 255;
            ec[k] = (r >= 0) ? 1 : 0;
            en_f[k] = (ex[k] >= 128) ? 1 : 0;
            ez[k] = (ex[k] == 0) ? 1 : 0;
            ea[k] = a_in;
         end else begin
            m = int'(a_in) & int'(operand);
            r = (int'(c_in) * 128) + (m / 2);
            en_f[k] = (r >= 128) ? 1 : 0;
            ez[k] = (r == 0) ? 1 : 0;
            ev[k] = ((r / 64) % 2) ^ ((r / 32) % 2);
            ex[k] = x_in;
            if (dec_ok && d_in) begin
               if ((m % 16) + (m % 2) > 5) r = (r / 16) * 16 + ((r % 16) + 6) % 16;
               cc = ((m / 16) + ((m / 16) % 2) > 5) ? 1 : 0;
               if (cc == 1) r = (r + 96) % 256;
               ec[k] = cc;
            end else begin
               ec[k] = (r / 64) % 2;
            end
            ea[k] = r;
         end
      end
   endtask

   task automatic compare(input string tag);
      total++;
      if (a_d != ea[0] || x_d != ex[0] || n_d != en_f[0] || z_d != ez[0] ||
          c_d != ec[0] || v_d != ev[0]) begin
         bad++;
         $display("FAIL %s dec: got a=%02h x=%02h nzcv=%b%b%b%b exp a=%02h x=%02h nzcv=%0d%0d%0d%0d",
            tag, a_d, x_d, n_d, z_d, c_d, v_d, ea[0], ex[0], en_f[0], ez[0], ec[0], ev[0]);
      end
      total++;
      if (a_b != ea[1] || x_b != ex[1] || n_b != en_f[1] || z_b != ez[1] ||
          c_b != ec[1] || v_b != ev[1]) begin
         bad++;
         $display("FAIL R8/%s bin: got a=%02h x=%02h nzcv=%b%b%b%b exp a=%02h x=%02h nzcv=%0d%0d%0d%0d",
            tag, a_b, x_b, n_b, z_b, c_b, v_b, ea[1], ex[1], en_f[1], ez[1], ec[1], ev[1]);
      end
   endtask

   task automatic step(input string tag, input bit r, input bit e, input bit op,
                       input int opnd, input int a, input int x, input bit c, input bit d);
      @(negedge clk);
      rst = r; en = e; op_sel = op; operand = 8'(opnd);
      a_in = 8'(a); x_in = 8'(x); c_in = c; d_in = d;
      @(posedge clk);
      model(0, 1'b1);
      model(1, 1'b0);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(20 * 100000);
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R1", 1, 1, 0, 8'hFF, 8'hFF, 8'h12, 1, 0);
      // R3/R4/R11 binary rotate
      step("R3", 0, 1, 0, 8'hFF, 8'hFF, 8'h5A, 1, 0);
      step("R4", 0, 1, 0, 8'hC3, 8'hF0, 8'h00, 0, 0);
      step("R3", 0, 1, 0, 8'h01, 8'h01, 8'h33, 0, 0);
      step("R11", 0, 1, 0, 8'h60, 8'hE0, 8'hA5, 0, 0);
      // R2: idle hold with changing inputs
      step("R2", 0, 0, 1, 8'h00, 8'h77, 8'h11, 1, 1);
      step("R2", 0, 0, 0, 8'hFF, 8'h00, 8'hFF, 0, 0);
      // R5/R6/R7 decimal rotate
      step("R6", 0, 1, 0, 8'hFF, 8'hFF, 8'h00, 1, 1);
      step("R5", 0, 1, 0, 8'h0F, 8'h07, 8'h00, 0, 1);
      step("R5", 0, 1, 0, 8'h05, 8'h05, 8'h00, 0, 1);
      step("R6", 0, 1, 0, 8'h50, 8'h50, 8'h00, 0, 1);
      step("R6", 0, 1, 0, 8'h60, 8'h40, 8'h00, 0, 1);
      step("R7", 0, 1, 0, 8'hAA, 8'hEE, 8'h00, 1, 1);
      step("R7", 0, 1, 0, 8'h00, 8'h00, 8'h00, 0, 1);
      // R9/R10 subtract
      step("R9", 0, 1, 1, 8'h10, 8'hF0, 8'h3C, 0, 0);
      step("R9", 0, 1, 1, 8'h40, 8'hF0, 8'h3C, 0, 0);
      step("R9", 0, 1, 1, 8'h30, 8'hF0, 8'h3C, 0, 1);
      step("R10", 0, 1, 0, 8'hFF, 8'h7F, 8'h00, 1, 0);
      step("R10", 0, 1, 1, 8'h01, 8'h9C, 8'hFF, 1, 0);
      step("R9", 0, 1, 1, 8'hFF, 8'h00, 8'h00, 0, 0);
      // random mix
      for (int i = 0; i < 2000; i++) begin
         step("RND", 0, ($urandom % 4) != 0, $urandom % 2, $urandom % 256,
              $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);
      end
      step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule